// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Control Register

This block turns a serial bit stream into a set of parallel channel enables. Each channel enable stands for the gate drive of one high-voltage switch. Bits enter on a serial input and move one stage along a shift chain on each clock edge where the shift strobe is high. A hold stage controlled by an active-low latch enable sits between the chain and the channel outputs. While the enable is low, the outputs follow the chain. While it is high, the outputs keep the last value they took.

The last stage of the chain drives a serial output, so several blocks can be chained: each serial output feeds the serial input of the next block, and all blocks share the clock and the shift strobe. An asynchronous active-high clear empties both the chain and the hold stage, which turns every channel off at once. The clear takes precedence over every other input.

The hold stage is a register with an enable in the clock domain, not a level-sensitive latch. "Transparent" therefore means that the hold stage is rewritten with the chain's next contents on every clock edge where the enable is sampled low.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While `clr_i` is high, every chain stage, every channel output and `dout_o` are 0. This takes effect without waiting for a clock edge and holds whatever `shift_en_i`, `le_n_i` or `din_i` do.
- R2: On a rising clock edge with `shift_en_i` high, stage 0 takes `din_i` and stage k+1 takes the old value of stage k. With `shift_en_i` low, the chain keeps its contents.
- R3: `dout_o` equals the last chain stage (CHANNELS-1). A bit shifted in therefore first appears on `dout_o` after exactly CHANNELS shift edges.
- R4: After CHANNELS shifts and a latch update, the last bit shifted in controls channel 0 and the first bit controls channel CHANNELS-1. A 1 on `chan_o[i]` means channel i is ON and a 0 means it is OFF.
- R5: On every clock edge where `le_n_i` is sampled low, `chan_o` takes the chain's new contents. Shifting with `le_n_i` low makes the outputs follow the moving data.
- R6: While `le_n_i` is sampled high, `chan_o` does not change, whatever shifting takes place.
- R7: After `le_n_i` rises, `chan_o` keeps the chain contents from the last edge at which `le_n_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clr_i | input | 1 | Asynchronous clear, active high; empties the chain and the hold stage |
| shift_en_i | input | 1 | Shift strobe; when high, the chain advances one stage on the edge |
| din_i | input | 1 | Serial data input into stage 0 |
| le_n_i | input | 1 | Latch enable, active low; low = outputs follow the chain, high = outputs hold |
| dout_o | output | 1 | Serial cascade output, the last chain stage |
| chan_o | output | CHANNELS | Channel enables, 1 = ON |

## Verification
The assertions check on every cycle the rules that relate neighbouring cycles:
- the chain advances one stage under the shift strobe and stays put without it;
- the outputs match the chain after each edge with the enable low, and stay stable while the enable is high;
- clear forces all outputs to zero.

Some behaviours only the bench scenarios can show:
- the reversed channel order after a full 16-bit load;
- the exact edge count before the first bit reaches the cascade output;
- the value captured when the enable rises in the middle of a shift burst;
- that an asynchronous clear between two edges zeroes the outputs at once.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  localparam int unsigned SW_DEFAULT_CHANNELS = 16;
  typedef enum logic {CH_OFF = 1'b0, CH_ON = 1'b1} ch_state_e;
endpackage

// File: rtl/sw_shift_chain.sv
module sw_shift_chain #(
  parameter int unsigned STAGES = sw_ctrl_pkg::SW_DEFAULT_CHANNELS
) (
  input  logic              clk_i,
  input  logic              clr_i,
  input  logic              shift_en_i,
  input  logic              din_i,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_d
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic feed;
    if (s == 0) begin : g_head
      assign feed = din_i;
    end else begin : g_body
      assign feed = stage_q[s-1];
    end
    assign stage_d[s] = shift_en_i ? feed : stage_q[s];
  end

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) stage_q <= '0;
    else       stage_q <= stage_d;
  end

  // R2: the chain moves one stage under the strobe
  p_advance_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    shift_en_i |=> (stage_q[0] == $past(din_i)) &&
                   (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));

  // R2: with no strobe the chain keeps its contents
  p_idle_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    !shift_en_i |=> $stable(stage_q));
endmodule

// File: rtl/sw_hold_stage.sv
module sw_hold_stage #(
  parameter int unsigned WIDTH = sw_ctrl_pkg::SW_DEFAULT_CHANNELS
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             le_n_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] hold_q
);
  for (genvar c = 0; c < WIDTH; c++) begin : g_cell
    always_ff @(posedge clk_i or posedge clr_i) begin
      if (clr_i)        hold_q[c] <= sw_ctrl_pkg::CH_OFF;
      else if (!le_n_i) hold_q[c] <= next_i[c];
    end
  end

  // R6: enable high freezes the outputs
  p_freeze_r6: assert property (@(posedge clk_i) disable iff (clr_i)
    le_n_i |=> $stable(hold_q));
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl #(
  parameter int unsigned CHANNELS = sw_ctrl_pkg::SW_DEFAULT_CHANNELS
) (
  input  logic                clk_i,
  input  logic                clr_i,
  input  logic                shift_en_i,
  input  logic                din_i,
  input  logic                le_n_i,
  output logic                dout_o,
  output logic [CHANNELS-1:0] chan_o
);
  localparam int unsigned TAIL = CHANNELS - 1;

  logic [CHANNELS-1:0] chain_q;
  logic [CHANNELS-1:0] chain_d;

  sw_shift_chain #(.STAGES(CHANNELS)) u_chain (
    .clk_i      (clk_i),
    .clr_i      (clr_i),
    .shift_en_i (shift_en_i),
    .din_i      (din_i),
    .stage_q    (chain_q),
    .stage_d    (chain_d)
  );

  sw_hold_stage #(.WIDTH(CHANNELS)) u_hold (
    .clk_i  (clk_i),
    .clr_i  (clr_i),
    .le_n_i (le_n_i),
    .next_i (chain_d),
    .hold_q (chan_o)
  );

  assign dout_o = chain_q[TAIL];

  // R5: outputs follow the chain after every edge with the enable low
  p_follow_r5: assert property (@(posedge clk_i) disable iff (clr_i)
    !le_n_i |=> (chan_o == chain_q));

  // R1: clear forces everything off
  p_clear_r1: assert property (@(posedge clk_i)
    clr_i |-> (chan_o == '0) && !dout_o && (chain_q == '0));
endmodule

// File: tb/serial_switch_ctrl_test.sv
`timescale 1ns/1ps
module serial_switch_ctrl_test;
  localparam int N = 16;
  localparam int NV = 6;
  // bit k of each word is the k-th bit sent on the serial input
  localparam logic [N-1:0] SEQ [NV] = '{16'h0001, 16'h8000, 16'hA5C3,
                                        16'hFFFF, 16'h0000, 16'h1234};

  logic clk = 0, clr = 1, sh = 0, din = 0, le_n = 1;
  logic dout;
  logic [N-1:0] chan;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  serial_switch_ctrl #(.CHANNELS(N)) uut (
    .clk_i(clk), .clr_i(clr), .shift_en_i(sh), .din_i(din),
    .le_n_i(le_n), .dout_o(dout), .chan_o(chan));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sh = 1; din = b;
    @(negedge clk);
    sh = 0;
  endtask

  task automatic latch_once();
    le_n = 0;
    @(negedge clk);
    le_n = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] exp_rev;
    logic [N-1:0] snap;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", chan, '0);
    chk("R1 reset dout", {15'd0, dout}, '0);
    clr = 0;
    @(negedge clk);

    // table walk: R4 ordering, R3 cascade bit, R6 hold while loading
    for (int v = 0; v < NV; v++) begin
      snap = chan;
      for (int k = 0; k < N; k++) shift_bit(SEQ[v][k]);
      chk("R6 load with enable high", chan, snap);
      chk("R3 dout holds first bit", {15'd0, dout}, {15'd0, SEQ[v][0]});
      latch_once();
      for (int k = 0; k < N; k++) exp_rev[N-1-k] = SEQ[v][k];
      chk("R4 channel order", chan, exp_rev);
    end

    // R2: no strobe, no shift
    snap = chan;
    din = ~dout; sh = 0;
    repeat (4) @(negedge clk);
    latch_once();
    chk("R2 chain idle without strobe", chan, snap);

    // R3: first bit reaches dout after exactly N shifts
    for (int k = 0; k < N; k++) shift_bit(1'b0);
    shift_bit(1'b1);
    for (int k = 1; k < N - 1; k++) shift_bit(1'b0);
    chk("R3 dout after N-1 shifts", {15'd0, dout}, '0);
    shift_bit(1'b0);
    chk("R3 dout after N shifts", {15'd0, dout}, 16'd1);

    // R5: transparent follow while shifting
    for (int k = 0; k < N; k++) shift_bit(1'b0);
    le_n = 0;
    shift_bit(1'b1);
    chk("R5 follow one shift", chan, 16'h0001);
    shift_bit(1'b1);
    chk("R5 follow two shifts", chan, 16'h0003);
    shift_bit(1'b0);
    chk("R5 follow three shifts", chan, 16'h0006);

    // R7: capture on enable rise, then shifting is ignored
    le_n = 1;
    shift_bit(1'b1);
    shift_bit(1'b1);
    chk("R7 capture at enable rise", chan, 16'h0006);
    latch_once();
    chk("R2 chain kept shifting behind hold", chan, 16'h001B);

    // R1: asynchronous clear mid-shift, held while strobes and enable run
    for (int k = 0; k < 8; k++) shift_bit(1'b1);
    latch_once();
    #2 clr = 1;
    #1;
    chk("R1 clear without edge", chan, '0);
    chk("R1 clear dout", {15'd0, dout}, '0);
    sh = 1; din = 1; le_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 clear overrides shift and enable", chan, '0);
    clr = 0; sh = 0; le_n = 1;
    @(negedge clk);
    latch_once();
    chk("R1 chain emptied by clear", chan, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule